// File: doc/BRIEF.md
# USB Bus Line-State Monitor

This block sits beside a USB device's transceiver and watches the two-bit line state it reports, together with a flag that marks an incoming packet. It sorts the bus into three classes: idle, reset or active. It also keeps a suspend level, which rises after a long quiet stretch and falls when the host wakes the bus. The block runs alongside the transaction engine and does not depend on it. Its only outputs are the status code, a one-cycle pulse at the end of each bus reset, the suspend level, and two free-running interval ticks.

All the thresholds come from a single clock-frequency parameter `CLK_KHZ`, given in kHz. The reset qualification time is `RESET_CYC = CLK_KHZ*25/10000` cycles, which is 2.5 µs and equals 120 cycles at 48 MHz. The suspend time is `SUSP_CYC = 3*CLK_KHZ` cycles, which is 3 ms. The 100 µs tick has a period of `CLK_KHZ/10` cycles and the 1 ms tick a period of `CLK_KHZ` cycles. These two ticks are provided for a later speed-negotiation block and are not used inside this block. Every output is registered or decoded from registers. The block samples its inputs on each rising clock edge.

Top module: `usb_bus_monitor`

## Requirements
- R1: Line codes are SE0 = 2'b00, J = 2'b01, K = 2'b10 and SE1 = 2'b11. On each edge, a sample of J with `rx_active_i` low sets `bus_status_o` to IDLE (2'b00). Any other sample that does not qualify as a reset sets it to ACTIVE (2'b10). The code 2'b11 never appears.
- R2: Suppose SE0 has been sampled on at least `RESET_CYC` consecutive edges before the current edge. If SE0 is also sampled on the current edge, `bus_status_o` becomes RESET (2'b01), and it stays RESET while SE0 continues.
- R3: A sample that is not SE0 restarts the SE0 run. So exactly `RESET_CYC` SE0 samples followed by a sample that is not SE0 produce neither RESET nor a pulse.
- R4: `reset_pulse_o` is high for exactly one cycle. It is set on the edge that samples the first value other than SE0 while the status is RESET. It is never set at any other time.
- R5: Suppose idle (J with no packet) has been sampled on at least `SUSP_CYC` consecutive edges. A further idle sample then sets `suspend_o`.
- R6: A K sample, an SE0 sample, an SE1 sample or a sample with `rx_active_i` high restarts the idle run.
- R7: While suspended, the edge that samples K clears `suspend_o`.
- R8: While suspended, an SE0 sample that qualifies as a reset (R2) clears `suspend_o`. Shorter SE0 runs leave `suspend_o` high.
- R9: `tick_100us_o` pulses for one cycle, once every `CLK_KHZ/10` cycles.
- R10: `tick_1ms_o` pulses for one cycle, once every `CLK_KHZ` cycles, and only in a cycle where `tick_100us_o` is also high.
- R11: After a synchronous active-low reset, the status is IDLE, `reset_pulse_o` is low and `suspend_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_state_i | input | 2 | Line state from the transceiver (SE0/J/K/SE1) |
| rx_active_i | input | 1 | High while a packet is being received |
| bus_status_o | output | 2 | IDLE 00, RESET 01, ACTIVE 10 |
| reset_pulse_o | output | 1 | One-cycle pulse at the end of a bus reset |
| suspend_o | output | 1 | High while the bus is suspended |
| tick_100us_o | output | 1 | 100 µs interval strobe |
| tick_1ms_o | output | 1 | 1 ms interval strobe |

## Verification
Some properties are checked on every cycle. The status code is always legal. RESET is only ever entered from SE0 samples. The end-of-reset pulse is single and always follows a RESET status. Suspend only rises after an idle sample and always falls on K. The run counters stay in bounds, and every millisecond tick coincides with a 100 µs tick. The exact thresholds can only be shown by the bench's scenarios against its reference model. These include the off-by-one edge of an SE0 run that falls one sample short of a reset, the restart of the 3 ms run by a single K, the survival of suspend across a short SE0, and the tick periods.

// File: rtl/usbmon_pkg.sv
package usbmon_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE   = 2'b00,
    BUS_RESET  = 2'b01,
    BUS_ACTIVE = 2'b10
  } bus_state_e;

  localparam logic [1:0] LINE_SE0 = 2'b00;
  localparam logic [1:0] LINE_J   = 2'b01;
  localparam logic [1:0] LINE_K   = 2'b10;
endpackage

// File: rtl/usbmon_runlen.sv
// Counts consecutive cycles in which hit_i is high, saturating at LIMIT.
module usbmon_runlen #(
  parameter int LIMIT = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  output logic full_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  assign full_o = (cnt == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (!hit_i) cnt <= '0;
    else if (!full_o) cnt <= cnt + CW'(1);
  end

  // R3 / R6: the run count never passes its limit
  a_r3_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM);
  // R3 / R6: a full run always ends on a hit sample
  a_r6_full_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> $past(hit_i));
endmodule

// File: rtl/usbmon_timebase.sv
// Free-running 100 us and 1 ms strobes derived from the clock frequency.
module usbmon_timebase #(
  parameter int CLK_KHZ = 48000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_100us_o,
  output logic tick_1ms_o
);
  localparam int T100 = CLK_KHZ / 10;
  localparam int DW   = (T100 > 1) ? $clog2(T100) : 1;
  localparam logic [DW-1:0] DLAST = DW'(T100 - 1);

  logic [DW-1:0] div_q;
  logic [3:0]    deci_q;

  assign tick_100us_o = (div_q == DLAST);
  assign tick_1ms_o   = tick_100us_o && (deci_q == 4'd9);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      deci_q <= '0;
    end else begin
      div_q <= tick_100us_o ? '0 : div_q + DW'(1);
      if (tick_100us_o) deci_q <= (deci_q == 4'd9) ? 4'd0 : deci_q + 4'd1;
    end
  end

  a_r10_ms_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1ms_o |-> tick_100us_o);
  a_r9_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_100us_o |=> !tick_100us_o);
endmodule

// File: rtl/usb_bus_monitor.sv
module usb_bus_monitor
  import usbmon_pkg::*;
#(
  parameter int CLK_KHZ = 48000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_state_i,
  input  logic       rx_active_i,
  output logic [1:0] bus_status_o,
  output logic       reset_pulse_o,
  output logic       suspend_o,
  output logic       tick_100us_o,
  output logic       tick_1ms_o
);
  localparam int RESET_CYC = CLK_KHZ * 25 / 10000;
  localparam int SUSP_CYC  = 3 * CLK_KHZ;

  logic       se0, kst, idle_s;
  logic       rst_qual, idle_qual;
  bus_state_e status_q;
  logic       pulse_q, susp_q;

  assign se0    = (line_state_i == LINE_SE0);
  assign kst    = (line_state_i == LINE_K);
  assign idle_s = (line_state_i == LINE_J) && !rx_active_i;

  usbmon_runlen #(.LIMIT(RESET_CYC)) u_se0_run (
    .clk(clk), .rst_n(rst_n), .hit_i(se0), .full_o(rst_qual));

  usbmon_runlen #(.LIMIT(SUSP_CYC)) u_idle_run (
    .clk(clk), .rst_n(rst_n), .hit_i(idle_s), .full_o(idle_qual));

  usbmon_timebase #(.CLK_KHZ(CLK_KHZ)) u_timebase (
    .clk(clk), .rst_n(rst_n),
    .tick_100us_o(tick_100us_o), .tick_1ms_o(tick_1ms_o));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= BUS_IDLE;
      pulse_q  <= 1'b0;
      susp_q   <= 1'b0;
    end else begin
      pulse_q <= (status_q == BUS_RESET) && !se0;
      if (rst_qual && se0) status_q <= BUS_RESET;
      else if (idle_s)     status_q <= BUS_IDLE;
      else                 status_q <= BUS_ACTIVE;
      if (susp_q) begin
        if (kst || (rst_qual && se0)) susp_q <= 1'b0;
      end else if (idle_qual && idle_s) begin
        susp_q <= 1'b1;
      end
    end
  end

  assign bus_status_o  = status_q;
  assign reset_pulse_o = pulse_q;
  assign suspend_o     = susp_q;

  a_r1_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bus_status_o != 2'b11);
  a_r2_reset_from_se0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_status_o == BUS_RESET) |-> $past(line_state_i == LINE_SE0));
  a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse_o |=> !reset_pulse_o);
  a_r4_pulse_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    reset_pulse_o |-> ($past(bus_status_o) == BUS_RESET));
  a_r5_enter_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspend_o) |-> $past((line_state_i == LINE_J) && !rx_active_i));
  a_r7_resume_on_k: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_o && line_state_i == LINE_K) |=> !suspend_o);
endmodule

// File: tb/tb_usb_bus_monitor.sv
`timescale 1ns/1ps
module tb_usb_bus_monitor;
  localparam int CLK_KHZ   = 4000;
  localparam int RESET_CYC = CLK_KHZ * 25 / 10000;
  localparam int SUSP_CYC  = 3 * CLK_KHZ;
  localparam int T100      = CLK_KHZ / 10;
  localparam int T1MS      = CLK_KHZ;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] line = 2'b01;
  logic       rxa = 1'b0;
  logic [1:0] bus_status;
  logic       reset_pulse, suspend, tick100, tick1ms;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last100 = -1;
  int last1ms = -1;

  int m_se0_run = 0, m_idle_run = 0;
  logic [1:0] m_status = 2'b00;
  logic m_pulse = 1'b0, m_susp = 1'b0;

  always #10 clk = ~clk;

  usb_bus_monitor #(.CLK_KHZ(CLK_KHZ)) dut (
    .clk(clk), .rst_n(rst_n), .line_state_i(line), .rx_active_i(rxa),
    .bus_status_o(bus_status), .reset_pulse_o(reset_pulse),
    .suspend_o(suspend), .tick_100us_o(tick100), .tick_1ms_o(tick1ms));

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model(input logic [1:0] ls, input logic ra);
    logic se0, idl, kk;
    logic [1:0] ns;
    logic np, nsus;
    se0 = (ls == 2'b00);
    kk  = (ls == 2'b10);
    idl = (ls == 2'b01) && !ra;
    np = (m_status == 2'b01) && !se0;
    nsus = m_susp;
    if (m_susp) begin
      if (kk || (m_se0_run >= RESET_CYC && se0)) nsus = 1'b0;
    end else if (m_idle_run >= SUSP_CYC && idl) nsus = 1'b1;
    if (m_se0_run >= RESET_CYC && se0) ns = 2'b01;
    else if (idl) ns = 2'b00;
    else ns = 2'b10;
    m_se0_run  = se0 ? m_se0_run + 1 : 0;
    m_idle_run = idl ? m_idle_run + 1 : 0;
    m_status = ns; m_pulse = np; m_susp = nsus;
  endtask

  task automatic step(input logic [1:0] ls, input logic ra, input string tag);
    @(negedge clk);
    line = ls; rxa = ra;
    @(posedge clk);
    model(ls, ra);
    cyc++;
    #1;
    check(tag, "bus_status", bus_status, m_status);
    check(tag, "reset_pulse", reset_pulse, m_pulse);
    check(tag, "suspend", suspend, m_susp);
    if (tick100) begin
      if (last100 >= 0) check("R9", "tick_100us period", cyc - last100, T100);
      last100 = cyc;
    end
    if (tick1ms) begin
      check("R10", "tick_1ms with tick_100us", tick100, 1);
      if (last1ms >= 0) check("R10", "tick_1ms period", cyc - last1ms, T1MS);
      last1ms = cyc;
    end
  endtask

  task automatic run(input logic [1:0] ls, input logic ra, input int n, input string tag);
    for (int i = 0; i < n; i++) step(ls, ra, tag);
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check("R11", "bus_status in reset", bus_status, 0);
    check("R11", "reset_pulse in reset", reset_pulse, 0);
    check("R11", "suspend in reset", suspend, 0);
    @(negedge clk);
    rst_n = 1'b1;

    run(2'b01, 1'b0, 20, "R1");
    run(2'b10, 1'b0, 5, "R1");
    run(2'b11, 1'b0, 2, "R1");
    run(2'b01, 1'b1, 3, "R1");
    run(2'b01, 1'b0, 3, "R1");
    // one sample short of a reset
    run(2'b00, 1'b0, RESET_CYC, "R3");
    run(2'b01, 1'b0, 3, "R3");
    // full reset then its end
    run(2'b00, 1'b0, RESET_CYC + 20, "R2");
    run(2'b01, 1'b0, 5, "R4");
    // suspend entry and resume on K
    run(2'b01, 1'b0, SUSP_CYC + 5, "R5");
    run(2'b10, 1'b0, 1, "R7");
    run(2'b01, 1'b0, 4, "R7");
    // a single K restarts the 3 ms run
    run(2'b01, 1'b0, SUSP_CYC / 2, "R6");
    run(2'b10, 1'b0, 1, "R6");
    run(2'b01, 1'b0, SUSP_CYC / 2 + 50, "R6");
    run(2'b01, 1'b1, 1, "R6");
    run(2'b01, 1'b0, SUSP_CYC - 10, "R6");
    // short SE0 keeps suspend, qualified SE0 clears it
    run(2'b01, 1'b0, SUSP_CYC + 3, "R5");
    run(2'b00, 1'b0, 5, "R8");
    run(2'b01, 1'b0, 3, "R8");
    run(2'b00, 1'b0, RESET_CYC + 5, "R8");
    run(2'b01, 1'b0, 5, "R4");
    // random mix
    for (int s = 0; s < 400; s++) begin
      int len;
      int pick;
      logic [1:0] ls;
      logic ra;
      pick = int'($urandom_range(0, 9));
      ls = (pick < 4) ? 2'b01 : (pick < 6) ? 2'b10 : (pick < 9) ? 2'b00 : 2'b11;
      ra = ($urandom_range(0, 3) == 0);
      len = int'($urandom_range(1, 3 * RESET_CYC));
      run(ls, ra, len, "R1");
    end
    run(2'b01, 1'b0, T1MS + 10, "R10");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule